// File: doc/BRIEF.md
# Programmable Bit Error Inserter

This block sits between a test-pattern generator and the serial transmit output. On each bit slot marked valid it passes the pattern bit through or inverts it, deliberately placing errors so that a far-end checker can be tested. The corrupted bit and a one-cycle marker for every inverted bit come out in the same cycle as the pattern bit. The path from the pattern bit to the output has no register.

Errors come from two sources. A 3-bit decade field sets a steady rate of one error per 10^n valid bits, or turns that source off. One-shot errors are requested by a software strobe or by a rising edge on an asynchronous manual pin. These requests are accepted only while a single-error enable is set, and each one inverts exactly one later valid bit.

Top module: `bit_err_inserter`

## Requirements
- R1: With `rate_sel` = n (1..7), the valid bit whose 1-based position, counted from the last change of `rate_sel`, is a multiple of 10^n is inverted. No other valid bit is inverted by this source.
- R2: `rate_sel` = 000 disables rate-based insertion.
- R3: In the cycle where `rate_sel` differs from its value in the previous cycle, the rate counter restarts. That slot is not counted, and the rate source inserts nothing in it.
- R4: Slots with `bit_valid` low are never corrupted and are not counted. In these slots `err_bit` equals `pat_bit` and `err_pulse` is low.
- R5: An error is made by inverting the bit (`err_bit` = not `pat_bit`). An uncorrupted valid bit passes unchanged in the same cycle.
- R6: A `sw_strobe` high in a cycle, while `single_en` is high, leaves one request pending. That request inverts the first valid bit in a later cycle and is then cleared.
- R7: `man_pin` passes through a two-flop synchronizer and is rising-edge detected. Each rising edge gives one request. With `bit_valid` held high, the error lands 3 cycles after the cycle in which the pin rises.
- R8: While `single_en` is low, strobes and pin edges are ignored. Clearing `single_en` discards a pending request.
- R9: Requests that arrive while one is already pending merge into a single error.
- R10: When a single error and a rate error fall on the same bit, the bit is inverted once and the pending request is consumed.
- R11: `err_pulse` is high for exactly those cycles in which the bit is corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Current slot carries a pattern bit |
| pat_bit | input | 1 | Pattern bit from the generator |
| rate_sel | input | 3 | Decade exponent n; 000 = off |
| single_en | input | 1 | Enables one-shot error requests |
| sw_strobe | input | 1 | Register strobe requesting one error |
| man_pin | input | 1 | Asynchronous manual error request pin |
| err_bit | output | 1 | Possibly inverted pattern bit |
| err_pulse | output | 1 | High on each corrupted bit |

## Verification
A rate counter that drifts or does not restart moves the error to a different valid bit. This shows up at `err_pulse` within one period of the selected decade, so every valid bit of two full periods is compared for n = 1 to 4. A pending flag that sticks, gets lost or is not cleared gives a missing, doubled or late inversion. The bench checks this on the very next valid slots after each strobe or pin edge. A synchronizer of the wrong depth moves the pin-driven error off its third-cycle slot.

// File: rtl/bit_err_inserter.sv
module bit_err_inserter #(
  parameter int EXP_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             pat_bit,
  input  logic [EXP_W-1:0] rate_sel,
  input  logic             single_en,
  input  logic             sw_strobe,
  input  logic             man_pin,
  output logic             err_bit,
  output logic             err_pulse
);
  localparam int MAX_EXP = (1 << EXP_W) - 1;
  localparam int CW = $clog2(10 ** MAX_EXP);

  function automatic logic [CW-1:0] dec_pow(input logic [EXP_W-1:0] e);
    logic [CW-1:0] p;
    p = CW'(1);
    for (int i = 0; i < MAX_EXP; i++)
      if (i < int'(e)) p = p * CW'(10);
    return p;
  endfunction

  logic [EXP_W-1:0] rate_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    lim;
  logic             rate_on, chg, term, rate_hit;

  assign lim      = dec_pow(rate_sel);
  assign rate_on  = (rate_sel != '0);
  assign chg      = (rate_sel != rate_q);
  assign term     = (cnt_q == lim - CW'(1));
  assign rate_hit = bit_valid & rate_on & ~chg & term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_sel;
      if (chg)
        cnt_q <= '0;
      else if (bit_valid && rate_on)
        cnt_q <= term ? '0 : cnt_q + CW'(1);
    end
  end

  logic [SYNC_STAGES:0] pin_sh;
  logic pin_rise, req, pend_q, serve;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[SYNC_STAGES-1:0], man_pin};
  end

  assign pin_rise = pin_sh[SYNC_STAGES-1] & ~pin_sh[SYNC_STAGES];
  assign req      = single_en & (sw_strobe | pin_rise);
  assign serve    = pend_q & bit_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= single_en & ((pend_q & ~bit_valid) | req);
  end

  assign err_pulse = rate_hit | serve;
  assign err_bit   = pat_bit ^ err_pulse;
endmodule

module bit_err_inserter_chk #(
  parameter int EXP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             pat_bit,
  input logic [EXP_W-1:0] rate_sel,
  input logic             single_en,
  input logic             err_bit,
  input logic             err_pulse,
  input logic             pend_q,
  input logic             req
);
  assert_idle_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> (!err_pulse && err_bit == pat_bit));

  assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_bit != pat_bit));

  assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel != $past(rate_sel) && !pend_q) |-> !err_pulse);

  assert_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0 && !single_en && !$past(single_en)) |-> !err_pulse);

  assert_pend_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bit_valid && !req) |=> !pend_q);

  assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !single_en |=> !pend_q);
endmodule

bind bit_err_inserter bit_err_inserter_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .pat_bit(pat_bit),
  .rate_sel(rate_sel), .single_en(single_en), .err_bit(err_bit),
  .err_pulse(err_pulse), .pend_q(pend_q), .req(req)
);

// File: tb/bit_err_inserter_tb.sv
`timescale 1ns/1ps
module bit_err_inserter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, pat_bit = 1'b0, single_en = 1'b0;
  logic sw_strobe = 1'b0, man_pin = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic err_bit, err_pulse;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bit_err_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .pat_bit(pat_bit),
    .rate_sel(rate_sel), .single_en(single_en), .sw_strobe(sw_strobe),
    .man_pin(man_pin), .err_bit(err_bit), .err_pulse(err_pulse)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic slot(input logic v, input logic b, input logic s, input logic m);
    @(negedge clk);
    bit_valid = v; pat_bit = b; sw_strobe = s; man_pin = m;
    #1;
  endtask

  task automatic expect_bit(input logic flip, input string req);
    chk(err_pulse == flip, req, int'(err_pulse), int'(flip));
    chk(err_bit == (pat_bit ^ flip), req, int'(err_bit), int'(pat_bit ^ flip));
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lim, idx, cnt;
    repeat (3) @(negedge clk);
    #1;
    expect_bit(1'b0, "reset R4");
    @(negedge clk); rst_n = 1'b1;

    // R1/R4/R5 rate sweep with gaps
    for (int n = 1; n <= 4; n++) begin
      lim = 1;
      for (int j = 0; j < n; j++) lim *= 10;
      @(negedge clk); bit_valid = 0; rate_sel = 3'(n); #1;
      expect_bit(1'b0, "R3 change slot");
      idx = 0;
      for (int i = 0; idx < 2 * lim + 3; i++) begin
        logic v, b;
        v = (i % 7) != 6;
        b = ((i * 5) / 3) % 2 == 1;
        slot(v, b, 1'b0, 1'b0);
        if (v) begin
          expect_bit(((idx + 1) % lim) == 0, "R1 rate position");
          idx++;
        end else expect_bit(1'b0, "R4 invalid slot");
      end
    end

    // R2 off
    slot(1'b0, 1'b0, 1'b0, 1'b0); rate_sel = 3'd0;
    for (int i = 0; i < 200; i++) begin
      slot(1'b1, i[0], 1'b0, 1'b0);
      expect_bit(1'b0, "R2 off");
    end

    // R3 restart: n=2 for 50 bits, then switch to n=1 on a valid slot
    slot(1'b0, 1'b0, 1'b0, 1'b0); rate_sel = 3'd2;
    for (int i = 0; i < 50; i++) slot(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); bit_valid = 1; pat_bit = 1; rate_sel = 3'd1; #1;
    expect_bit(1'b0, "R3 change slot not counted");
    for (int k = 0; k < 25; k++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      expect_bit(((k + 1) % 10) == 0, "R3 restart position");
    end

    // R1 top decade: no error in first 1000 bits
    slot(1'b0, 1'b0, 1'b0, 1'b0); rate_sel = 3'd7;
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      cnt += int'(err_pulse);
    end
    chk(cnt == 0, "R1 n=7 early", cnt, 0);
    slot(1'b0, 1'b0, 1'b0, 1'b0); rate_sel = 3'd0;
    slot(1'b0, 1'b0, 1'b0, 1'b0);

    // R6 strobe
    single_en = 1;
    slot(1'b1, 1'b1, 1'b1, 1'b0);
    expect_bit(1'b0, "R6 strobe slot");
    slot(1'b1, 1'b1, 1'b0, 1'b0);
    expect_bit(1'b1, "R6 next valid inverted");
    slot(1'b1, 1'b0, 1'b0, 1'b0);
    expect_bit(1'b0, "R6 cleared");

    // R6 wait across invalid slots
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      slot(1'b0, 1'b1, 1'b0, 1'b0);
      expect_bit(1'b0, "R6 held while invalid");
    end
    slot(1'b1, 1'b0, 1'b0, 1'b0);
    expect_bit(1'b1, "R6 first valid served");

    // R9 merge
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      cnt += int'(err_pulse);
    end
    chk(cnt == 1, "R9 merged count", cnt, 1);

    // R8 disabled requests
    single_en = 0;
    slot(1'b1, 1'b0, 1'b1, 1'b0);
    slot(1'b1, 1'b0, 1'b0, 1'b1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      cnt += int'(err_pulse);
    end
    chk(cnt == 0, "R8 ignored when disabled", cnt, 0);
    // R8 discard pending
    single_en = 1;
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    slot(1'b0, 1'b0, 1'b0, 1'b0);
    single_en = 0;
    slot(1'b0, 1'b0, 1'b0, 1'b0);
    single_en = 1;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b0);
      cnt += int'(err_pulse);
    end
    chk(cnt == 0, "R8 pending discarded", cnt, 0);

    // R7 manual pin: error in slot 3 only
    for (int i = 0; i < 12; i++) begin
      slot(1'b1, 1'b1, 1'b0, 1'b1);
      expect_bit(i == 3, "R7 pin position");
    end
    for (int i = 0; i < 6; i++) slot(1'b1, 1'b0, 1'b0, 1'b0);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      slot(1'b1, 1'b0, 1'b0, 1'b1);
      cnt += int'(err_pulse);
    end
    chk(cnt == 1, "R7 second edge", cnt, 1);
    slot(1'b1, 1'b0, 1'b0, 1'b0);

    // R10/R11 coincidence
    slot(1'b0, 1'b0, 1'b0, 1'b0); rate_sel = 3'd1;
    for (int k = 0; k < 12; k++) begin
      slot(1'b1, 1'b1, k == 8, 1'b0);
      if (k == 9) expect_bit(1'b1, "R10 single inversion");
      else        expect_bit(1'b0, "R11 no extra pulse");
    end

    finish_run();
  end
endmodule